// File: doc/BRIEF.md
# Debug Command Port Controller

This block is an on-chip debug port that sits between an external debug interface device and a processor core. The host issues one 8-bit command code at a time. It then supplies any operand words on a shared 32-bit data path. The port turns each command into a request to the core: a register, memory or I/O access, or a change of the core's execution state. Read results and trace words go back out on the same data path. The pad tristate is steered by an output-enable signal.

A 14-bit status word reports several things. It shows whether the port can take a command and whether the last command finished. It also carries the core's execution state, the console-mode and trace flags, an error flag, and what the data path is carrying. The pins are shared with self-test and boundary-scan logic, so a grant input decides when this port owns them. Without the grant the port neither listens nor drives.

Top module: `dbg_cmd_port`

## Requirements
- R1: After reset the status word reads 14'h401 while the grant is high: ready (bit 0) and grant (bit 10) set, execution state running (bits 3:2 = 00), every other bit clear. The data path is not driven, no core request is raised and the core run enable is high.
- R2: Access command codes are: register 8'h10 read / 8'h11 write; memory 8'h20 read / 8'h21 write; I/O 8'h30 read / 8'h31 write. A read takes one operand word (register number or address). A write takes two, the target first and then the data. The core request then carries space 0 = register, 1 = memory, 2 = I/O, the write flag, the target and the data. It holds them stable until the core acknowledges.
- R3: When a read completes, the value returned by the core is driven on `data_out` with `data_oe` high and status bit 8 set. It stays there until the next command is accepted.
- R4: Ready (bit 0) drops in the cycle after a command is accepted and stays low until complete (bit 1) rises. Complete is cleared by every accepted command.
- R5: An undefined command code sets the sticky error flag (bit 7) and complete. The port stays idle, and the core sees neither a request nor a change of run state.
- R6: Access commands are refused while console mode (bit 4) is off. Console mode is entered with 8'h50 and left with 8'h51. A refused access sets the error flag and raises no core request.
- R7: Single step (8'h42) is honoured only from the stopped state. It raises the run enable until the core reports one retired instruction, then returns to stopped (bits 3:2 = 01). A step from any other state is an error and leaves the run state alone.
- R8: Run (8'h40) sets execution state running (00) with run enable high. Stop (8'h41) sets stopped (01) with run enable low.
- R9: `data_oe` is high only in the read-result phase and the idle trace phase. It is never high while operands are being collected or a core request is open.
- R10: Trace on (8'h60) makes every trace word offered by the core appear on `data_out` one cycle later with `data_oe` and status bit 6 set, while the port is idle. Trace off (8'h61) stops this. Bit 5 shows the trace flag.
- R11: While the grant is low, ready is low, `data_oe` is low and command strobes are ignored.
- R12: Debug reset (8'h70) gives a one-cycle `core_rst` pulse. It sets the execution state to stopped and clears console mode, trace and error.
- R13: Memory read-next (8'h22, no operand) and memory write-next (8'h23, one data word) use the previous target address plus 4.
- R14: The no-op command is 8'h00. Error clear (8'h71) clears bit 7. State read (8'h72) returns a word with the execution state in bits 1:0, console in bit 2, trace in bit 3 and error in bit 4, as a read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_grant | input | 1 | High when this port owns the shared pins |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| data_valid | input | 1 | Operand word strobe |
| data_in | input | 32 | Operand word from the host |
| data_out | output | 32 | Read result or trace word toward the host |
| data_oe | output | 1 | Drive enable for the shared data pins |
| status | output | 14 | Status word |
| core_req | output | 1 | Access request to the core |
| core_space | output | 2 | Access space: 0 register, 1 memory, 2 I/O |
| core_we | output | 1 | Access is a write |
| core_addr | output | 32 | Register number or address |
| core_wdata | output | 32 | Write data |
| core_ack | input | 1 | Core finished the access |
| core_rdata | input | 32 | Read value, valid with the acknowledge |
| core_retire | input | 1 | One instruction retired this cycle |
| core_run | output | 1 | Core run enable |
| core_rst | output | 1 | One-cycle debug reset pulse to the core |
| trace_valid | input | 1 | Trace word offered this cycle |
| trace_word | input | 32 | Trace word from the core |

## Verification
The assertions assume a well-behaved host and core. The host strobes `data_valid` only after a command that takes operands, one word per strobe. It never sends an operand while the port drives the pins, and it holds the grant steady through a command. The core acknowledges only an open request, and it reports retirements only while its run enable is high. The bench keeps to this contract. Its core model answers each request two cycles after it appears and retires an instruction in every cycle the run enable is high. The directed tasks send operands only after the matching command and wait for complete before moving on.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    localparam int CMD_W  = 8;
    localparam int STAT_W = 14;

    // status word bit positions
    localparam int ST_READY = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_EXEC  = 2;   // two bits
    localparam int ST_CON   = 4;
    localparam int ST_TRC   = 5;
    localparam int ST_TVLD  = 6;
    localparam int ST_ERR   = 7;
    localparam int ST_RDV   = 8;
    localparam int ST_PEND  = 9;
    localparam int ST_GRANT = 10;

    // command codes
    localparam logic [CMD_W-1:0] C_NOP      = 8'h00;
    localparam logic [CMD_W-1:0] C_REG_RD   = 8'h10;
    localparam logic [CMD_W-1:0] C_REG_WR   = 8'h11;
    localparam logic [CMD_W-1:0] C_MEM_RD   = 8'h20;
    localparam logic [CMD_W-1:0] C_MEM_WR   = 8'h21;
    localparam logic [CMD_W-1:0] C_MEM_RDN  = 8'h22;
    localparam logic [CMD_W-1:0] C_MEM_WRN  = 8'h23;
    localparam logic [CMD_W-1:0] C_IO_RD    = 8'h30;
    localparam logic [CMD_W-1:0] C_IO_WR    = 8'h31;
    localparam logic [CMD_W-1:0] C_RUN      = 8'h40;
    localparam logic [CMD_W-1:0] C_STOP     = 8'h41;
    localparam logic [CMD_W-1:0] C_STEP     = 8'h42;
    localparam logic [CMD_W-1:0] C_CON_ON   = 8'h50;
    localparam logic [CMD_W-1:0] C_CON_OFF  = 8'h51;
    localparam logic [CMD_W-1:0] C_TRC_ON   = 8'h60;
    localparam logic [CMD_W-1:0] C_TRC_OFF  = 8'h61;
    localparam logic [CMD_W-1:0] C_DBG_RST  = 8'h70;
    localparam logic [CMD_W-1:0] C_ERR_CLR  = 8'h71;
    localparam logic [CMD_W-1:0] C_STATE_RD = 8'h72;

    typedef enum logic [2:0] {
        S_IDLE, S_OPND, S_REQ, S_SWAIT, S_FIN, S_RDATA
    } seq_st_e;

    typedef enum logic [1:0] {
        X_RUN  = 2'b00,
        X_STOP = 2'b01,
        X_STEP = 2'b10
    } exec_e;

    typedef enum logic [3:0] {
        K_ACCESS, K_RUN, K_STOP, K_STEP, K_CON_ON, K_CON_OFF, K_RESET,
        K_TRC_ON, K_TRC_OFF, K_NOP, K_ERR_CLR, K_STATE_RD
    } kind_e;

    typedef enum logic [1:0] {
        SP_REG = 2'd0,
        SP_MEM = 2'd1,
        SP_IO  = 2'd2
    } space_e;

    typedef struct packed {
        logic       known;
        kind_e      kind;
        space_e     space;
        logic       we;
        logic [1:0] nops;   // operand words still to come
        logic       bump;   // target is previous address plus step
    } dec_t;

endpackage

// File: rtl/dbgp_decode.sv
module dbgp_decode
    import dbgp_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output dec_t             dec
);

    always_comb begin
        dec       = '0;
        dec.known = 1'b1;
        dec.kind  = K_NOP;
        case (code)
            C_REG_RD:   begin dec.kind = K_ACCESS; dec.space = SP_REG; dec.nops = 2'd1; end
            C_REG_WR:   begin dec.kind = K_ACCESS; dec.space = SP_REG; dec.we = 1'b1; dec.nops = 2'd2; end
            C_MEM_RD:   begin dec.kind = K_ACCESS; dec.space = SP_MEM; dec.nops = 2'd1; end
            C_MEM_WR:   begin dec.kind = K_ACCESS; dec.space = SP_MEM; dec.we = 1'b1; dec.nops = 2'd2; end
            C_MEM_RDN:  begin dec.kind = K_ACCESS; dec.space = SP_MEM; dec.bump = 1'b1; end
            C_MEM_WRN:  begin dec.kind = K_ACCESS; dec.space = SP_MEM; dec.we = 1'b1; dec.nops = 2'd1; dec.bump = 1'b1; end
            C_IO_RD:    begin dec.kind = K_ACCESS; dec.space = SP_IO;  dec.nops = 2'd1; end
            C_IO_WR:    begin dec.kind = K_ACCESS; dec.space = SP_IO;  dec.we = 1'b1; dec.nops = 2'd2; end
            C_RUN:      dec.kind = K_RUN;
            C_STOP:     dec.kind = K_STOP;
            C_STEP:     dec.kind = K_STEP;
            C_CON_ON:   dec.kind = K_CON_ON;
            C_CON_OFF:  dec.kind = K_CON_OFF;
            C_TRC_ON:   dec.kind = K_TRC_ON;
            C_TRC_OFF:  dec.kind = K_TRC_OFF;
            C_DBG_RST:  dec.kind = K_RESET;
            C_ERR_CLR:  dec.kind = K_ERR_CLR;
            C_STATE_RD: dec.kind = K_STATE_RD;
            C_NOP:      dec.kind = K_NOP;
            default:    dec.known = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbgp_seq.sv
module dbgp_seq
    import dbgp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              cmd_valid,
    input  dec_t              dec,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              core_retire,
    output logic              core_req,
    output logic [1:0]        core_space,
    output logic              core_we,
    output logic [DATA_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    output logic              core_run,
    output logic              core_rst,
    output logic              idle_ph,
    output logic              rd_ph,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        exec_code,
    output logic              con_on,
    output logic              trc_on,
    output logic              err,
    output logic              done,
    output logic              ready
);

    localparam logic [DATA_W-1:0] STEP_V = DATA_W'(ADDR_STEP);

    typedef struct packed {
        seq_st_e           st;
        dec_t              cmd;
        logic [1:0]        left;
        logic              wsel;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        exec_e             exec;
        logic              con;
        logic              trc;
        logic              err;
        logic              done;
        logic              rstp;
    } seq_t;

    seq_t q, n;
    logic accept;

    assign accept = grant && cmd_valid && (q.st == S_IDLE || q.st == S_RDATA);

    always_comb begin
        n      = q;
        n.rstp = 1'b0;
        case (q.st)
            S_IDLE, S_RDATA: begin
                if (accept) begin
                    n.done = 1'b0;
                    n.cmd  = dec;
                    n.st   = S_FIN;
                    if (!dec.known) begin
                        n.err  = 1'b1;
                        n.done = 1'b1;
                        n.st   = S_IDLE;
                    end else begin
                        case (dec.kind)
                            K_ACCESS: begin
                                if (!q.con) begin
                                    n.err  = 1'b1;
                                    n.done = 1'b1;
                                    n.st   = S_IDLE;
                                end else begin
                                    n.wsel = dec.bump;
                                    n.left = dec.nops;
                                    if (dec.bump) n.addr = q.addr + STEP_V;
                                    n.st = (dec.nops == 2'd0) ? S_REQ : S_OPND;
                                end
                            end
                            K_STEP: begin
                                if (q.exec != X_STOP) begin
                                    n.err  = 1'b1;
                                    n.done = 1'b1;
                                    n.st   = S_IDLE;
                                end else begin
                                    n.exec = X_STEP;
                                    n.st   = S_SWAIT;
                                end
                            end
                            K_RUN:     n.exec = X_RUN;
                            K_STOP:    n.exec = X_STOP;
                            K_CON_ON:  n.con  = 1'b1;
                            K_CON_OFF: n.con  = 1'b0;
                            K_TRC_ON:  n.trc  = 1'b1;
                            K_TRC_OFF: n.trc  = 1'b0;
                            K_ERR_CLR: n.err  = 1'b0;
                            K_RESET: begin
                                n.rstp = 1'b1;
                                n.exec = X_STOP;
                                n.con  = 1'b0;
                                n.trc  = 1'b0;
                                n.err  = 1'b0;
                            end
                            K_STATE_RD: begin
                                n.rdata      = '0;
                                n.rdata[4:0] = {q.err, q.trc, q.con, q.exec};
                            end
                            default: ;
                        endcase
                    end
                end
            end
            S_OPND: begin
                if (data_valid) begin
                    if (!q.wsel) n.addr  = data_in;
                    else         n.wdata = data_in;
                    n.wsel = 1'b1;
                    n.left = q.left - 2'd1;
                    if (q.left == 2'd1) n.st = S_REQ;
                end
            end
            S_REQ: begin
                if (core_ack) begin
                    n.done = 1'b1;
                    if (q.cmd.we) begin
                        n.st = S_IDLE;
                    end else begin
                        n.rdata = core_rdata;
                        n.st    = S_RDATA;
                    end
                end
            end
            S_SWAIT: begin
                if (core_retire) begin
                    n.exec = X_STOP;
                    n.done = 1'b1;
                    n.st   = S_IDLE;
                end
            end
            S_FIN: begin
                n.done = 1'b1;
                n.st   = (q.cmd.kind == K_STATE_RD) ? S_RDATA : S_IDLE;
            end
            default: n.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign core_req   = (q.st == S_REQ);
    assign core_space = q.cmd.space;
    assign core_we    = q.cmd.we;
    assign core_addr  = q.addr;
    assign core_wdata = q.wdata;
    assign core_run   = (q.exec == X_RUN) || (q.exec == X_STEP);
    assign core_rst   = q.rstp;
    assign idle_ph    = (q.st == S_IDLE);
    assign rd_ph      = (q.st == S_RDATA);
    assign rdata      = q.rdata;
    assign exec_code  = q.exec;
    assign con_on     = q.con;
    assign trc_on     = q.trc;
    assign err        = q.err;
    assign done       = q.done;
    assign ready      = grant && (q.st == S_IDLE || q.st == S_RDATA);

    // R2: an open request keeps its target and data until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_req && !core_ack |=> core_req && $stable(core_addr) && $stable(core_wdata));

    // R4: complete is low through every busy state
    p_busy_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {S_OPND, S_REQ, S_SWAIT, S_FIN}) |-> !q.done && !ready);

    // R5: an undefined code leaves the port idle with the error flag up
    p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec.known |=> q.st == S_IDLE && q.err && !core_req);

    // R6: no core request for an access outside console mode
    p_no_console_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && dec.known && dec.kind == K_ACCESS && !q.con |=> !core_req);

    // R7: the run enable falls right after the single retired instruction
    p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.exec == X_STEP && core_retire |=> !core_run && q.exec == X_STOP);

    // R12: debug reset is a single-cycle pulse and leaves the core stopped
    p_rst_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> !core_rst && q.exec == X_STOP);

endmodule

// File: rtl/dbgp_bus.sv
module dbgp_bus #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              trc_on,
    input  logic              idle_ph,
    input  logic              rd_ph,
    input  logic [DATA_W-1:0] rdata,
    input  logic              trace_valid,
    input  logic [DATA_W-1:0] trace_word,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              trace_shown
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              vld;
    } trc_t;

    trc_t q, n;
    logic show_trc;

    always_comb begin
        n      = q;
        n.vld  = trc_on && trace_valid;
        if (trace_valid) n.word = trace_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign show_trc    = grant && idle_ph && q.vld;
    assign trace_shown = show_trc;
    assign data_oe     = (grant && rd_ph) || show_trc;
    assign data_out    = rd_ph ? rdata : (show_trc ? q.word : '0);

    // R9: the pins are driven only in a read-result or idle trace phase
    p_oe_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (rd_ph || idle_ph));

    // R11: without the grant nothing is driven
    p_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |-> !data_oe);

endmodule

// File: rtl/dbg_cmd_port.sv
module dbg_cmd_port
    import dbgp_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_grant,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              data_valid,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [STAT_W-1:0] status,
    output logic              core_req,
    output logic [1:0]        core_space,
    output logic              core_we,
    output logic [DATA_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    input  logic              core_ack,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              core_retire,
    output logic              core_run,
    output logic              core_rst,
    input  logic              trace_valid,
    input  logic [DATA_W-1:0] trace_word
);

    dec_t              dec;
    logic              idle_ph, rd_ph, con_on, trc_on, err, done, ready, trace_shown;
    logic [1:0]        exec_code;
    logic [DATA_W-1:0] rdata;

    dbgp_decode i_decode (
        .code (cmd_code),
        .dec  (dec)
    );

    dbgp_seq #(
        .DATA_W    (DATA_W),
        .ADDR_STEP (ADDR_STEP)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (pin_grant),
        .cmd_valid   (cmd_valid),
        .dec         (dec),
        .data_valid  (data_valid),
        .data_in     (data_in),
        .core_ack    (core_ack),
        .core_rdata  (core_rdata),
        .core_retire (core_retire),
        .core_req    (core_req),
        .core_space  (core_space),
        .core_we     (core_we),
        .core_addr   (core_addr),
        .core_wdata  (core_wdata),
        .core_run    (core_run),
        .core_rst    (core_rst),
        .idle_ph     (idle_ph),
        .rd_ph       (rd_ph),
        .rdata       (rdata),
        .exec_code   (exec_code),
        .con_on      (con_on),
        .trc_on      (trc_on),
        .err         (err),
        .done        (done),
        .ready       (ready)
    );

    dbgp_bus #(
        .DATA_W (DATA_W)
    ) i_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (pin_grant),
        .trc_on      (trc_on),
        .idle_ph     (idle_ph),
        .rd_ph       (rd_ph),
        .rdata       (rdata),
        .trace_valid (trace_valid),
        .trace_word  (trace_word),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .trace_shown (trace_shown)
    );

    always_comb begin
        status                        = '0;
        status[ST_READY]              = ready;
        status[ST_DONE]               = done;
        status[ST_EXEC+1:ST_EXEC]     = exec_code;
        status[ST_CON]                = con_on;
        status[ST_TRC]                = trc_on;
        status[ST_TVLD]               = trace_shown;
        status[ST_ERR]                = err;
        status[ST_RDV]                = rd_ph && pin_grant;
        status[ST_PEND]               = core_req;
        status[ST_GRANT]              = pin_grant;
    end

    // R9: the port never drives the pins while a core request is open
    p_no_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !core_req);

    // R3: read data shown on the pins is flagged in the status word
    p_rdv_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RDV] |-> data_oe && !status[ST_TVLD]);

endmodule

// File: tb/test_dbg_cmd_port.sv
`timescale 1ns/1ps
module test_dbg_cmd_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_grant = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic        data_valid = 1'b0;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic        data_oe;
    logic [13:0] status;
    logic        core_req;
    logic [1:0]  core_space;
    logic        core_we;
    logic [31:0] core_addr;
    logic [31:0] core_wdata;
    logic        core_ack = 1'b0;
    logic [31:0] core_rdata = '0;
    logic        core_retire = 1'b0;
    logic        core_run;
    logic        core_rst;
    logic        trace_valid = 1'b0;
    logic [31:0] trace_word = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int rq_cnt  = 0;
    int xact_cnt = 0;
    int retire_cnt = 0;
    logic [1:0]  last_space = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_addr = '0;
    logic [31:0] last_wdata = '0;

    always #5 clk = ~clk;

    dbg_cmd_port i_dbg_cmd_port (
        .clk(clk), .rst_n(rst_n), .pin_grant(pin_grant),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .data_valid(data_valid), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .status(status),
        .core_req(core_req), .core_space(core_space), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_ack(core_ack), .core_rdata(core_rdata),
        .core_retire(core_retire), .core_run(core_run), .core_rst(core_rst),
        .trace_valid(trace_valid), .trace_word(trace_word)
    );

    function automatic logic [31:0] mdl(input logic [1:0] sp, input logic [31:0] a);
        return a ^ 32'h5A5A_0000 ^ {30'h0, sp};
    endfunction

    // core model: acknowledge on the second request cycle, retire while running
    always @(negedge clk) begin
        if (core_req) begin
            if (rq_cnt == 1) begin
                core_ack   = 1'b1;
                core_rdata = mdl(core_space, core_addr);
                last_space = core_space;
                last_we    = core_we;
                last_addr  = core_addr;
                last_wdata = core_wdata;
                xact_cnt++;
            end else begin
                core_ack = 1'b0;
            end
            rq_cnt++;
        end else begin
            rq_cnt   = 0;
            core_ack = 1'b0;
        end
        core_retire = core_run;
        if (core_run) retire_cnt++;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_code  = c;
        cmd_valid = 1'b1;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        data_in    = w;
        data_valid = 1'b1;
        step();
        data_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 40; i++) begin
            if (status[1]) break;
            step();
        end
    endtask

    task automatic t_reset();
        chk("R1", "status", 32'(status), 32'h401);
        chk("R1", "oe", 32'(data_oe), 0);
        chk("R1", "req", 32'(core_req), 0);
        chk("R1", "run", 32'(core_run), 1);
    endtask

    task automatic t_unknown();
        int x0 = xact_cnt;
        send_cmd(8'hEE);
        chk("R5", "status", 32'(status), 32'h483);
        chk("R5", "run", 32'(core_run), 1);
        step();
        chk("R5", "no xact", 32'(xact_cnt), 32'(x0));
        send_cmd(8'h71);
        wait_done();
        chk("R14", "err cleared", 32'(status[7]), 0);
    endtask

    task automatic t_no_console();
        int x0 = xact_cnt;
        send_cmd(8'h20);
        chk("R6", "err", 32'(status[7]), 1);
        chk("R6", "ready", 32'(status[0]), 1);
        repeat (4) step();
        chk("R6", "no xact", 32'(xact_cnt), 32'(x0));
        send_cmd(8'h71);
        wait_done();
    endtask

    task automatic t_reg_write();
        send_cmd(8'h50);
        wait_done();
        chk("R6", "console flag", 32'(status[4]), 1);
        send_cmd(8'h11);
        chk("R4", "ready low", 32'(status[0]), 0);
        chk("R4", "done low", 32'(status[1]), 0);
        chk("R9", "no drive in operand phase", 32'(data_oe), 0);
        send_word(32'd5);
        send_word(32'hCAFE_0001);
        chk("R9", "no drive in request", 32'(data_oe), 0);
        wait_done();
        chk("R4", "ready after done", 32'(status[0]), 1);
        chk("R2", "space", 32'(last_space), 0);
        chk("R2", "we", 32'(last_we), 1);
        chk("R2", "reg number", last_addr, 32'd5);
        chk("R2", "wdata", last_wdata, 32'hCAFE_0001);
    endtask

    task automatic t_mem_read();
        send_cmd(8'h20);
        send_word(32'h0000_0100);
        wait_done();
        chk("R3", "oe", 32'(data_oe), 1);
        chk("R3", "data", data_out, mdl(2'd1, 32'h100));
        chk("R3", "rd flag", 32'(status[8]), 1);
        chk("R2", "read not write", 32'(last_we), 0);
        step();
        chk("R3", "held", data_out, mdl(2'd1, 32'h100));
        send_cmd(8'h22);
        chk("R3", "released on next cmd", 32'(data_oe), 0);
        wait_done();
        chk("R13", "read-next addr", last_addr, 32'h104);
        chk("R13", "read-next data", data_out, mdl(2'd1, 32'h104));
        send_cmd(8'h23);
        send_word(32'h1234_5678);
        wait_done();
        chk("R13", "write-next addr", last_addr, 32'h108);
        chk("R13", "write-next data", last_wdata, 32'h1234_5678);
        send_cmd(8'h00);
        wait_done();
        chk("R14", "nop done", 32'(status[1:0]), 32'h3);
    endtask

    task automatic t_io();
        send_cmd(8'h31);
        send_word(32'h0000_0040);
        send_word(32'h0000_00AB);
        wait_done();
        chk("R2", "io space", 32'(last_space), 2);
        chk("R2", "io addr", last_addr, 32'h40);
        send_cmd(8'h30);
        send_word(32'h0000_0044);
        wait_done();
        chk("R3", "io read data", data_out, mdl(2'd2, 32'h44));
    endtask

    task automatic t_trace();
        send_cmd(8'h60);
        wait_done();
        chk("R10", "trace flag", 32'(status[5]), 1);
        trace_word  = 32'hDEAD_BEEF;
        trace_valid = 1'b1;
        step();
        chk("R10", "oe", 32'(data_oe), 1);
        chk("R10", "word", data_out, 32'hDEAD_BEEF);
        chk("R10", "tvld", 32'(status[6]), 1);
        trace_word = 32'h0000_7777;
        step();
        chk("R10", "next word", data_out, 32'h0000_7777);
        trace_valid = 1'b0;
        step();
        chk("R10", "idle no drive", 32'(data_oe), 0);
        send_cmd(8'h61);
        wait_done();
        trace_valid = 1'b1;
        step();
        chk("R10", "off no drive", 32'(data_oe), 0);
        trace_valid = 1'b0;
    endtask

    task automatic t_grant();
        pin_grant = 1'b0;
        step();
        chk("R11", "ready", 32'(status[0]), 0);
        send_cmd(8'h41);
        chk("R11", "oe", 32'(data_oe), 0);
        pin_grant = 1'b1;
        step();
        chk("R11", "stop ignored", 32'(status[3:2]), 0);
        chk("R11", "still running", 32'(core_run), 1);
    endtask

    task automatic t_run_step();
        int r0;
        send_cmd(8'h41);
        wait_done();
        chk("R8", "stopped", 32'(status[3:2]), 1);
        chk("R8", "run low", 32'(core_run), 0);
        step();
        r0 = retire_cnt;
        send_cmd(8'h42);
        wait_done();
        step();
        chk("R7", "one retire", 32'(retire_cnt - r0), 1);
        chk("R7", "stopped after step", 32'(status[3:2]), 1);
        chk("R7", "run low", 32'(core_run), 0);
        send_cmd(8'h40);
        wait_done();
        chk("R8", "running", 32'(status[3:2]), 0);
        chk("R8", "run high", 32'(core_run), 1);
        send_cmd(8'h42);
        chk("R7", "step while running err", 32'(status[7]), 1);
        chk("R7", "still running", 32'(status[3:2]), 0);
    endtask

    task automatic t_state_rd();
        send_cmd(8'h72);
        wait_done();
        chk("R14", "state word", data_out, 32'h14);
        chk("R14", "oe", 32'(data_oe), 1);
    endtask

    task automatic t_dbg_rst();
        send_cmd(8'h60);
        wait_done();
        send_cmd(8'h70);
        chk("R12", "pulse", 32'(core_rst), 1);
        step();
        chk("R12", "pulse ends", 32'(core_rst), 0);
        chk("R12", "status", 32'(status), 32'h407);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_unknown();
        t_no_console();
        t_reg_write();
        t_mem_read();
        t_io();
        t_trace();
        t_grant();
        t_run_step();
        t_state_rd();
        t_dbg_rst();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule